// File: doc/BRIEF.md
# Supply-Loss Write Guard for Battery-Backed Memory

This block sits between a host and a battery-backed static memory and keeps the memory contents safe while the main supply sags, fails or comes back. Three external comparators report the supply as digital flags: above the full-operation level (3.0 V), above the protection trip point (between 2.8 V and 3.0 V), and above the battery switchover point (about 2.5 V). The flags pass through synchronizers and are decoded into one supply level. An inconsistent flag pattern always counts as the lowest level that any cleared flag points to.

When the supply falls to the trip point, the guard blocks writes. It forces the memory chip-enable and write-enable inactive and requests high impedance on the data outputs, whatever the host drives. Below the switchover point it selects the battery as the memory supply, but only once the one-time freshness seal has been broken. The seal breaks the first time the supply reaches the full-operation level. After that it stays broken across ordinary resets, and only a dedicated factory-clear input restores it.

Once the supply is valid again, protection stays on for a programmable number of clock cycles. That hold models the long recovery interval the memory needs. Any dip during the hold starts it over.

Top module: `pwrGuard`

## Requirements
- R1: While `rstN` is low, and directly after it rises, `wrProtect`, `memCeN`, `memWeN` and `outHiZ` are 1 and `battSel` is 0.
- R2: The flags decode to a level as follows: `supSwitch`=0 gives battery level, else `supTrip`=0 gives low level, else `supOk`=0 gives margin level, else good level. A higher flag that is set does not lift the level above one given by a lower flag that is cleared.
- R3: When the synchronized level is below the trip point (battery or low level), `wrProtect` is 1. This takes effect two rising clock edges after the raw flag change.
- R4: While `wrProtect` is 1, `memCeN`=1, `memWeN`=1 and `outHiZ`=1, whatever the values of `hostCeN` and `hostWeN`.
- R5: While `wrProtect` is 0, `memCeN` follows `hostCeN` and `memWeN` follows `hostWeN`. `outHiZ` is 1 when `hostCeN`=1 or `hostWeN`=0, and 0 otherwise.
- R6: The margin level does not start protection while the block is running, and it does not start the recovery hold while the block is protected.
- R7: After the raw flags first show the good level while the block is protected, `wrProtect` falls on rising edge 3+RECOV_CYCLES and not earlier.
- R8: Any non-good level during the recovery hold returns the block to protection. A fresh full hold, timed as in R7 from the return of the good level, is then needed.
- R9: `sealArmed` rises on the third rising edge after the raw flags first show the good level. It stays 1 through `rstN` pulses and all supply levels, and only `sealClrN` low clears it.
- R10: With `sealArmed`=1, `battSel` is 1 exactly when the level three edges earlier was battery level. It is registered, so it changes on the third edge after a raw flag change.
- R11: While `sealArmed` is 0, `battSel` stays 0 even at battery level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset of synchronizers, state machine and battery select |
| sealClrN | input | 1 | Active-low factory clear of the freshness seal |
| supOk | input | 1 | Comparator: supply above full-operation level |
| supTrip | input | 1 | Comparator: supply above protection trip point |
| supSwitch | input | 1 | Comparator: supply above battery switchover point |
| hostCeN | input | 1 | Host chip-enable, active low |
| hostWeN | input | 1 | Host write-enable, active low |
| wrProtect | output | 1 | Write protection active |
| memCeN | output | 1 | Gated memory chip-enable, active low |
| memWeN | output | 1 | Gated memory write-enable, active low |
| outHiZ | output | 1 | Request to float the memory data outputs |
| battSel | output | 1 | Memory supply taken from the battery |
| sealArmed | output | 1 | Freshness seal broken, battery backup armed |

## Verification
Each result has a fixed delay after a raw flag change. The decoded level, and with it the gating and the protect flag on a fall, appears two edges later. The seal and the battery select appear three edges later. Release from protection comes on edge 3+RECOV_CYCLES. Host strobes reach the gated outputs in the same cycle. The bench changes inputs only on falling edges and checks just before the next falling edge, so every check reads the outputs after a known number of rising edges. A reference model in the bench moves in step on the same rising edges and gives the expected value for every output in every cycle. Directed checks sample one edge before and on the edge where each delay ends.

// File: rtl/pwrGuardPkg.sv
package pwrGuardPkg;

  localparam int FLAG_N   = 3;
  localparam int FLAG_SW  = 0;
  localparam int FLAG_TRP = 1;
  localparam int FLAG_OK  = 2;

  typedef enum logic [1:0] {
    LVL_BATT   = 2'd0,
    LVL_LOW    = 2'd1,
    LVL_MARGIN = 2'd2,
    LVL_GOOD   = 2'd3
  } supplyLvl_t;

  typedef enum logic [1:0] {
    ST_PROT  = 2'd0,
    ST_RECOV = 2'd1,
    ST_RUN   = 2'd2
  } guardState_t;

  typedef struct packed {
    logic holdProt;
    logic battConnect;
  } ctrlStrobe_t;

endpackage

// File: rtl/pwrGuardPath.sv
module pwrGuardPath
  import pwrGuardPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_N-1:0] rawFlags,
  input  logic              hostCeN,
  input  logic              hostWeN,
  input  ctrlStrobe_t       strobe,
  output supplyLvl_t        lvl,
  output logic              belowTrip,
  output logic              wrProtect,
  output logic              memCeN,
  output logic              memWeN,
  output logic              outHiZ,
  output logic              battSel
);

  logic [FLAG_N-1:0] stageQ [SYNC_STAGES];
  logic [FLAG_N-1:0] syncFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= rawFlags;
      for (int s = 1; s < SYNC_STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncFlags = stageQ[SYNC_STAGES-1];

  // lowest cleared flag wins, so inconsistent patterns fall to the lower level
  always_comb begin
    if (!syncFlags[FLAG_SW])       lvl = LVL_BATT;
    else if (!syncFlags[FLAG_TRP]) lvl = LVL_LOW;
    else if (!syncFlags[FLAG_OK])  lvl = LVL_MARGIN;
    else                           lvl = LVL_GOOD;
  end

  assign belowTrip = (lvl == LVL_BATT) || (lvl == LVL_LOW);

  // immediate gating on the synchronized level, ahead of the state register
  assign wrProtect = strobe.holdProt | belowTrip;
  assign memCeN    = hostCeN | wrProtect;
  assign memWeN    = hostWeN | wrProtect;
  assign outHiZ    = wrProtect | hostCeN | ~hostWeN;
  assign battSel   = strobe.battConnect;

endmodule

// File: rtl/pwrGuardCtrl.sv
module pwrGuardCtrl
  import pwrGuardPkg::*;
#(
  parameter int RECOV_CYCLES = 6250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sealClrN,
  input  supplyLvl_t  lvl,
  input  logic        belowTrip,
  output ctrlStrobe_t strobe,
  output logic        sealArmed
);

  localparam int CNT_W = $clog2(RECOV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECOV_CYCLES - 1);

  guardState_t state, stateNext;
  logic [CNT_W-1:0] holdCnt, holdCntNext;
  logic lvlGood;
  logic battReg;

  assign lvlGood = (lvl == LVL_GOOD);

  always_comb begin
    stateNext   = state;
    holdCntNext = holdCnt;
    unique case (state)
      ST_RUN: begin
        if (belowTrip) stateNext = ST_PROT;
      end
      ST_PROT: begin
        if (lvlGood) begin
          stateNext   = ST_RECOV;
          holdCntNext = '0;
        end
      end
      ST_RECOV: begin
        if (!lvlGood)                 stateNext = ST_PROT;
        else if (holdCnt == CNT_LAST) stateNext = ST_RUN;
        else                          holdCntNext = holdCnt + CNT_W'(1);
      end
      default: stateNext = ST_PROT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PROT;
      holdCnt <= '0;
      battReg <= 1'b0;
    end else begin
      state   <= stateNext;
      holdCnt <= holdCntNext;
      battReg <= sealArmed && (lvl == LVL_BATT);
    end
  end

  // seal survives ordinary reset; only the factory clear restores it
  always_ff @(posedge clk or negedge sealClrN) begin
    if (!sealClrN)    sealArmed <= 1'b0;
    else if (lvlGood) sealArmed <= 1'b1;
  end

  assign strobe.holdProt    = (state != ST_RUN);
  assign strobe.battConnect = battReg;

  AST_TRIP_PROTECTS: assert property (@(posedge clk) disable iff (!rstN)
    belowTrip |=> (state != ST_RUN)); // R3

  AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_RUN) |-> $past(lvl == LVL_GOOD)); // R7

  AST_DIP_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOV && !lvlGood) |=> (state == ST_PROT)); // R8

  AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (!sealClrN)
    sealArmed |=> sealArmed); // R9

  AST_BATT_NEEDS_SEAL: assert property (@(posedge clk) disable iff (!rstN || !sealClrN)
    battReg |-> $past(sealArmed)); // R11

endmodule

// File: rtl/pwrGuard.sv
module pwrGuard
  import pwrGuardPkg::*;
#(
  parameter int RECOV_CYCLES = 6250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sealClrN,
  input  logic supOk,
  input  logic supTrip,
  input  logic supSwitch,
  input  logic hostCeN,
  input  logic hostWeN,
  output logic wrProtect,
  output logic memCeN,
  output logic memWeN,
  output logic outHiZ,
  output logic battSel,
  output logic sealArmed
);

  ctrlStrobe_t strobe;
  supplyLvl_t  lvl;
  logic        belowTrip;
  logic [FLAG_N-1:0] rawFlags;

  always_comb begin
    rawFlags           = '0;
    rawFlags[FLAG_SW]  = supSwitch;
    rawFlags[FLAG_TRP] = supTrip;
    rawFlags[FLAG_OK]  = supOk;
  end

  pwrGuardPath #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .rawFlags(rawFlags),
    .hostCeN(hostCeN), .hostWeN(hostWeN), .strobe(strobe),
    .lvl(lvl), .belowTrip(belowTrip), .wrProtect(wrProtect),
    .memCeN(memCeN), .memWeN(memWeN), .outHiZ(outHiZ), .battSel(battSel)
  );

  pwrGuardCtrl #(.RECOV_CYCLES(RECOV_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .sealClrN(sealClrN),
    .lvl(lvl), .belowTrip(belowTrip),
    .strobe(strobe), .sealArmed(sealArmed)
  );

endmodule

// File: tb/pwrGuard_test.sv
module pwrGuard_test;

  localparam int RC = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0, sealClrN = 1'b0;
  logic rawOk = 1'b1, rawTrip = 1'b1, rawSw = 1'b1;
  logic hostCeN = 1'b1, hostWeN = 1'b1;
  logic wrProtect, memCeN, memWeN, outHiZ, battSel, sealArmed;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwrGuard #(.RECOV_CYCLES(RC)) uut (
    .clk(clk), .rstN(rstN), .sealClrN(sealClrN),
    .supOk(rawOk), .supTrip(rawTrip), .supSwitch(rawSw),
    .hostCeN(hostCeN), .hostWeN(hostWeN),
    .wrProtect(wrProtect), .memCeN(memCeN), .memWeN(memWeN),
    .outHiZ(outHiZ), .battSel(battSel), .sealArmed(sealArmed)
  );

  // reference model built from the requirements
  logic [2:0] mA, mB;
  int mSt, mCnt;
  bit mSeal, mBatt;

  function automatic int lvlOf(logic [2:0] f); // f = {ok, trip, sw}
    if (!f[0]) return 0;
    if (!f[1]) return 1;
    if (!f[2]) return 2;
    return 3;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA <= '0; mB <= '0; mSt <= 0; mCnt <= 0; mBatt <= 0;
    end else begin
      mA <= {rawOk, rawTrip, rawSw};
      mB <= mA;
      mBatt <= mSeal && (lvlOf(mB) == 0);
      case (mSt)
        2: if (lvlOf(mB) < 2) mSt <= 0;
        0: if (lvlOf(mB) == 3) begin mSt <= 1; mCnt <= 0; end
        default: begin
          if (lvlOf(mB) != 3) mSt <= 0;
          else if (mCnt == RC - 1) mSt <= 2;
          else mCnt <= mCnt + 1;
        end
      endcase
    end
  end

  always @(posedge clk or negedge sealClrN) begin
    if (!sealClrN) mSeal <= 0;
    else if (lvlOf(mB) == 3) mSeal <= 1;
  end

  task automatic chk(string tag, logic got, logic exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit expProt();
    return (mSt != 2) || (lvlOf(mB) < 2);
  endfunction

  task automatic cmpAll();
    bit p;
    p = expProt();
    chk("R7 wrProtect", wrProtect, p);
    chk(p ? "R4 memCeN" : "R5 memCeN", memCeN, hostCeN | p);
    chk(p ? "R4 memWeN" : "R5 memWeN", memWeN, hostWeN | p);
    chk(p ? "R4 outHiZ" : "R5 outHiZ", outHiZ, p | hostCeN | ~hostWeN);
    chk("R10 battSel", battSel, mBatt);
    chk("R9 sealArmed", sealArmed, mSeal);
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cmpAll();
    end
  endtask

  task automatic setLvl(int l);
    rawSw   = (l >= 1);
    rawTrip = (l >= 2);
    rawOk   = (l >= 3);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    setLvl(1);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wrProtect", wrProtect, 1'b1);
    chk("R1 memCeN", memCeN, 1'b1);
    chk("R1 memWeN", memWeN, 1'b1);
    chk("R1 outHiZ", outHiZ, 1'b1);
    chk("R1 battSel", battSel, 1'b0);
    sealClrN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    step(1);
    chk("R1 wrProtect after release", wrProtect, 1'b1);
    // R11: battery level but seal intact
    setLvl(0);
    step(6);
    chk("R11 battSel unarmed", battSel, 1'b0);
    // R7 / R9: first good power-up
    setLvl(3);
    step(2);
    chk("R9 seal not yet", sealArmed, 1'b0);
    step(1);
    chk("R9 seal set", sealArmed, 1'b1);
    step(RC - 1);
    chk("R7 held", wrProtect, 1'b1);
    step(1);
    chk("R7 released", wrProtect, 1'b0);
    // R5 host pass-through
    hostCeN = 1'b0; hostWeN = 1'b0;
    step(1);
    chk("R5 write memWeN", memWeN, 1'b0);
    chk("R5 write outHiZ", outHiZ, 1'b1);
    hostWeN = 1'b1;
    step(1);
    chk("R5 read outHiZ", outHiZ, 1'b0);
    // R6 margin while running
    setLvl(2);
    step(5);
    chk("R6 margin runs", wrProtect, 1'b0);
    // R3 trip timing, R4 gating with host active
    hostWeN = 1'b0;
    setLvl(1);
    step(1);
    chk("R3 not yet", wrProtect, 1'b0);
    step(1);
    chk("R3 protected", wrProtect, 1'b1);
    chk("R4 memWeN", memWeN, 1'b1);
    chk("R4 memCeN", memCeN, 1'b1);
    chk("R4 outHiZ", outHiZ, 1'b1);
    // R6 margin does not start recovery
    setLvl(2);
    step(RC + 6);
    chk("R6 margin holds", wrProtect, 1'b1);
    // R2 inconsistent: ok=1 trip=0 sw=1 counts as low
    setLvl(3);
    step(RC + 4);
    chk("R2 good released", wrProtect, 1'b0);
    rawOk = 1'b1; rawTrip = 1'b0; rawSw = 1'b1;
    step(2);
    chk("R2 inconsistent protects", wrProtect, 1'b1);
    // R8 dip during recovery
    setLvl(3);
    step(3 + RC / 2);
    setLvl(2);
    step(1);
    setLvl(3);
    step(2 + RC);
    chk("R8 restart held", wrProtect, 1'b1);
    step(1);
    chk("R8 restart released", wrProtect, 1'b0);
    // R10 battery select timing
    setLvl(0);
    step(2);
    chk("R10 battSel not yet", battSel, 1'b0);
    step(1);
    chk("R10 battSel on", battSel, 1'b1);
    // R9 survives reset, cleared by factory input
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
    chk("R9 seal after reset", sealArmed, 1'b1);
    sealClrN = 1'b0;
    step(1);
    chk("R9 seal cleared", sealArmed, 1'b0);
    sealClrN = 1'b1;
    step(4);
    chk("R11 battSel after clear", battSel, 1'b0);
    // random phase
    for (int seg = 0; seg < 200; seg++) begin
      int hold;
      if ($urandom_range(99) < 15) begin
        rawOk = 1'($urandom); rawTrip = 1'($urandom); rawSw = 1'($urandom);
      end else begin
        setLvl(int'($urandom_range(3)));
      end
      hold = ($urandom_range(99) < 30) ? int'($urandom_range(60, 30))
                                       : int'($urandom_range(12, 1));
      for (int c = 0; c < hold; c++) begin
        hostCeN = 1'($urandom);
        hostWeN = 1'($urandom);
        step(1);
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule